// File: doc/BRIEF.md
# Asynchronous Memory Bank Strobe Controller

This block drives the control strobes of up to four external asynchronous memory banks: one chip-select per bank, a shared output-enable, a read strobe and a write strobe. A request carries an address, a read/write flag, write data and a one-cycle start pulse. The two most significant address bits pick the bank. The block then walks through an optional turnaround gap, a setup phase, an access phase and a hold phase. It finishes with a one-cycle done pulse. For reads, that pulse comes with the captured read data.

Each bank's timing comes from a 16-bit field. Two such fields are packed into each of two 32-bit configuration words. Inside a field, bit 0 enables ready sampling and bit 1 gives the ready polarity. Bits 3:2 hold the turnaround code, bits 5:4 the setup code and bits 7:6 the hold code. Bits 11:8 hold the read access code and bits 15:12 the write access code. A 3-bit enable code limits which banks may be used. The external ready pin can stretch the access phase of a bank that has ready enabled.

Top module: `async_bank_strobe`

## Requirements
- R1: The enable code selects the usable banks: 000 none, 001 bank 0, 010 banks 0-1, 011 banks 0-2, and any code with bit 2 set selects all four. A request to an unusable bank drives no strobe, does not assert busy, and gives done and err together in the cycle after the start pulse.
- R2: The bank is given by the top two address bits. Only that bank's chip-select (bit n of the chip-select bus for bank n) goes low during the access, and at most one chip-select is low at any time.
- R3: Setup: chip-select and output-enable are low for the setup count before the read or write strobe falls. Setup codes 1 to 3 give 1 to 3 cycles, and code 0 gives 4 cycles.
- R4: The read strobe stays low for the read access code (bits 11:8) and the write strobe for the write access code (bits 15:12), from 1 to 15 cycles, with code 0 treated as 1. The read and write strobes are never low together. The write data stays on the memory data bus while the write strobe is low.
- R5: Hold: after the strobe rises, chip-select and output-enable stay low for the hold code, 0 to 3 cycles. In the next cycle all strobes are high, busy is low and done pulses for one cycle.
- R6: A write whose previous completed access was a read first spends the turnaround count of its own bank idle, with busy high and all strobes high. Turnaround codes 1 to 3 give 1 to 3 cycles, and code 0 gives 4. Read after read, write after write and read after write have no gap.
- R7: With ready enabled for the bank, ready is sampled from the last programmed access cycle onward, and the strobe stays low until ready is seen at its asserted level (polarity bit 1 means high, 0 means low). With ready disabled, the ready pin has no effect on timing.
- R8: Bank 0 uses bits 15:0 and bank 1 uses bits 31:16 of the low configuration word. Banks 2 and 3 use the same halves of the high configuration word.
- R9: After reset all strobes are high, and done, err and busy are low. They stay that way while no request is in progress.
- R10: The address is held on the memory address bus for the whole access. Read data is sampled at the end of the last read access cycle and is presented on the read data output together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bank_en | input | 3 | Bank enable code |
| cfg_tmg_lo | input | 32 | Timing fields of banks 0 (low half) and 1 (high half) |
| cfg_tmg_hi | input | 32 | Timing fields of banks 2 (low half) and 3 (high half) |
| req_start | input | 1 | One-cycle request pulse, accepted when busy is low |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Request address, top two bits select the bank |
| req_wdata | input | DATA_W | Write data |
| ready_in | input | 1 | External ready pin |
| mem_rdata | input | DATA_W | Memory read data |
| mem_cs_n | output | 4 | Active-low chip-select per bank |
| mem_oe_n | output | 1 | Active-low output-enable |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion was a rejected request |
| rdata | output | DATA_W | Captured read data |

## Verification
The assertions check the cycle-invariant properties on every cycle:
- At most one chip-select is low.
- The read and write strobes are never low together.
- Output-enable is already low when a strobe falls.
- A done or error pulse never coincides with an active strobe.
- A stretched access keeps its strobe low while ready is absent.

The exact durations of setup, access, hold and turnaround for each code can only be shown by the bench, which compares every output against its behavioural model on every clock. The same holds for the wrap of code 0 to the maximum, the polarity of ready, the effect of each enable code, and the returned read data.

// File: rtl/asbc_pkg.sv
package asbc_pkg;

  localparam int FIELD_W = 16;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_TURN,
    PH_SETUP,
    PH_ACC,
    PH_HOLD
  } phase_t;

  // Decoded per-bank timing, all counts in cycles
  typedef struct packed {
    logic       rdy_en;
    logic       rdy_pol;
    logic [3:0] turn;
    logic [3:0] setup;
    logic [3:0] hold;
    logic [3:0] rd_acc;
    logic [3:0] wr_acc;
  } bank_tmg_t;

  function automatic bank_tmg_t decode_tmg(input logic [FIELD_W-1:0] f);
    bank_tmg_t t;
    t.rdy_en  = f[0];
    t.rdy_pol = f[1];
    t.turn    = (f[3:2] == 2'd0) ? 4'd4 : {2'b00, f[3:2]};
    t.setup   = (f[5:4] == 2'd0) ? 4'd4 : {2'b00, f[5:4]};
    t.hold    = {2'b00, f[7:6]};
    t.rd_acc  = (f[11:8] == 4'd0) ? 4'd1 : f[11:8];
    t.wr_acc  = (f[15:12] == 4'd0) ? 4'd1 : f[15:12];
    return t;
  endfunction

endpackage

// File: rtl/asbc_bank_decode.sv
module asbc_bank_decode
  import asbc_pkg::*;
#(
  parameter int NBANK  = 4,
  localparam int BANK_W = $clog2(NBANK)
) (
  input  logic [2:0]               en_code,
  input  logic [NBANK*FIELD_W-1:0] cfg_words,
  input  logic [BANK_W-1:0]        sel,
  output bank_tmg_t                tmg,
  output logic                     bank_ok
);

  bank_tmg_t          tmg_arr [NBANK];
  logic [NBANK-1:0]   en_mask;

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    assign tmg_arr[i] = decode_tmg(cfg_words[i*FIELD_W +: FIELD_W]);
    // code 1xx: all banks; otherwise banks below the 2-bit count
    assign en_mask[i] = en_code[2] | (32'(en_code[1:0]) > i);
  end

  assign tmg     = tmg_arr[sel];
  assign bank_ok = en_mask[sel];

endmodule

// File: rtl/asbc_sequencer.sv
module asbc_sequencer
  import asbc_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int DATA_W = 16,
  localparam int BANK_W = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              write,
  input  logic [BANK_W-1:0] bank,
  input  logic              bank_ok,
  input  bank_tmg_t         tmg,
  input  logic              ready_in,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [NBANK-1:0]  cs_n,
  output logic              oe_n,
  output logic              rd_n,
  output logic              we_n,
  output logic              done,
  output logic              err,
  output logic              busy,
  output logic              take,
  output logic [DATA_W-1:0] rdata
);

  phase_t            state, nxt_state;
  logic [3:0]        cnt, nxt_cnt;
  bank_tmg_t         cur_tmg;
  logic              cur_write;
  logic [BANK_W-1:0] cur_bank;
  logic              last_rd;
  logic              finish, finish_err, capture;
  logic              rdy_ok;
  logic [3:0]        acc_len;
  logic [BANK_W-1:0] nxt_bank;
  logic              nxt_write;
  logic              nxt_active;

  assign rdy_ok  = !cur_tmg.rdy_en || (ready_in == cur_tmg.rdy_pol);
  assign acc_len = cur_write ? cur_tmg.wr_acc : cur_tmg.rd_acc;
  assign busy    = (state != PH_IDLE);

  always_comb begin
    nxt_state  = state;
    nxt_cnt    = cnt;
    finish     = 1'b0;
    finish_err = 1'b0;
    capture    = 1'b0;
    take       = 1'b0;
    case (state)
      PH_IDLE: begin
        if (start) begin
          if (!bank_ok) begin
            finish_err = 1'b1;
          end else begin
            take = 1'b1;
            if (write && last_rd) begin
              nxt_state = PH_TURN;
              nxt_cnt   = tmg.turn - 4'd1;
            end else begin
              nxt_state = PH_SETUP;
              nxt_cnt   = tmg.setup - 4'd1;
            end
          end
        end
      end
      PH_TURN: begin
        if (cnt == 4'd0) begin
          nxt_state = PH_SETUP;
          nxt_cnt   = cur_tmg.setup - 4'd1;
        end else begin
          nxt_cnt = cnt - 4'd1;
        end
      end
      PH_SETUP: begin
        if (cnt == 4'd0) begin
          nxt_state = PH_ACC;
          nxt_cnt   = acc_len - 4'd1;
        end else begin
          nxt_cnt = cnt - 4'd1;
        end
      end
      PH_ACC: begin
        if (cnt != 4'd0) begin
          nxt_cnt = cnt - 4'd1;
        end else if (rdy_ok) begin
          capture = !cur_write;
          if (cur_tmg.hold == 4'd0) begin
            nxt_state = PH_IDLE;
            finish    = 1'b1;
          end else begin
            nxt_state = PH_HOLD;
            nxt_cnt   = cur_tmg.hold - 4'd1;
          end
        end
      end
      PH_HOLD: begin
        if (cnt == 4'd0) begin
          nxt_state = PH_IDLE;
          finish    = 1'b1;
        end else begin
          nxt_cnt = cnt - 4'd1;
        end
      end
      default: nxt_state = PH_IDLE;
    endcase
  end

  assign nxt_bank   = take ? bank  : cur_bank;
  assign nxt_write  = take ? write : cur_write;
  assign nxt_active = (nxt_state == PH_SETUP) || (nxt_state == PH_ACC) ||
                      (nxt_state == PH_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PH_IDLE;
      cnt       <= '0;
      cur_tmg   <= '0;
      cur_write <= 1'b0;
      cur_bank  <= '0;
      last_rd   <= 1'b0;
      cs_n      <= '1;
      oe_n      <= 1'b1;
      rd_n      <= 1'b1;
      we_n      <= 1'b1;
      done      <= 1'b0;
      err       <= 1'b0;
      rdata     <= '0;
    end else begin
      state <= nxt_state;
      cnt   <= nxt_cnt;
      if (take) begin
        cur_tmg   <= tmg;
        cur_write <= write;
        cur_bank  <= bank;
      end
      if (finish) last_rd <= !cur_write;
      if (capture) rdata <= mem_rdata;
      done <= finish | finish_err;
      err  <= finish_err;
      cs_n <= nxt_active ? ~(NBANK'(1) << nxt_bank) : '1;
      oe_n <= !nxt_active;
      rd_n <= !((nxt_state == PH_ACC) && !nxt_write);
      we_n <= !((nxt_state == PH_ACC) && nxt_write);
    end
  end

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n)); // R2

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !we_n)); // R4

  AST_SETUP_LEAD: assert property (@(posedge clk) disable iff (rst)
    ($fell(rd_n) || $fell(we_n)) |-> $past(!oe_n)); // R3

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    err |-> (done && (&cs_n) && oe_n)); // R1

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (oe_n && rd_n && we_n)); // R5

  AST_RDY_STRETCH: assert property (@(posedge clk) disable iff (rst)
    (state == PH_ACC && cnt == 4'd0 && !rdy_ok) |=> (!rd_n || !we_n)); // R7

endmodule

// File: rtl/async_bank_strobe.sv
module async_bank_strobe
  import asbc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cfg_bank_en,
  input  logic [31:0]       cfg_tmg_lo,
  input  logic [31:0]       cfg_tmg_hi,
  input  logic              req_start,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ready_in,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [3:0]        mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_rd_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata
);

  localparam int NBANK  = 4;
  localparam int BANK_W = $clog2(NBANK);

  logic [BANK_W-1:0] sel;
  bank_tmg_t         sel_tmg;
  logic              sel_ok;
  logic              take;

  assign sel = req_addr[ADDR_W-1 -: BANK_W];

  asbc_bank_decode #(.NBANK(NBANK)) u_decode (
    .en_code   (cfg_bank_en),
    .cfg_words ({cfg_tmg_hi, cfg_tmg_lo}),
    .sel       (sel),
    .tmg       (sel_tmg),
    .bank_ok   (sel_ok)
  );

  asbc_sequencer #(.NBANK(NBANK), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (req_start),
    .write     (req_write),
    .bank      (sel),
    .bank_ok   (sel_ok),
    .tmg       (sel_tmg),
    .ready_in  (ready_in),
    .mem_rdata (mem_rdata),
    .cs_n      (mem_cs_n),
    .oe_n      (mem_oe_n),
    .rd_n      (mem_rd_n),
    .we_n      (mem_we_n),
    .done      (done),
    .err       (err),
    .busy      (busy),
    .take      (take),
    .rdata     (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (take) begin
      mem_addr  <= req_addr;
      mem_wdata <= req_wdata;
    end
  end

endmodule

// File: tb/async_bank_strobe_bench.sv
module async_bank_strobe_bench;

  localparam int AW = 20;
  localparam int DW = 16;

  typedef struct {
    logic [3:0]  cs;
    logic        oe, rd, we, dn, er, bz, rdy;
    logic        chk_rd;
    logic [15:0] rd_exp;
    logic        chk_wd;
    logic [15:0] wd_exp;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst;
  logic [2:0]    en;
  logic [31:0]   lo, hi;
  logic          start, wr, rdy;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] mrd;
  logic [3:0]    mem_cs_n;
  logic          mem_oe_n, mem_rd_n, mem_we_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          busy, done, err;
  logic [DW-1:0] rdata;

  int   total = 0;
  int   bad = 0;
  exp_t q[$];
  bit   last_rd_m = 1'b0;

  assign mrd = mem_addr[15:0] ^ 16'h5AC3;

  async_bank_strobe #(.ADDR_W(AW), .DATA_W(DW)) u_async_bank_strobe (
    .clk(clk), .rst(rst), .cfg_bank_en(en), .cfg_tmg_lo(lo), .cfg_tmg_hi(hi),
    .req_start(start), .req_write(wr), .req_addr(addr), .req_wdata(wdata),
    .ready_in(rdy), .mem_rdata(mrd), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_rd_n(mem_rd_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy), .done(done), .err(err), .rdata(rdata)
  );

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // R8: bank n field is half n%2 of word n/2
  function automatic logic [15:0] fld(int b);
    case (b)
      0: return lo[15:0];
      1: return lo[31:16];
      2: return hi[15:0];
      default: return hi[31:16];
    endcase
  endfunction

  function automatic int wrap4(logic [1:0] c);
    return (c == 2'd0) ? 4 : int'(c);
  endfunction

  function automatic bit usable(int b);
    return en[2] ? 1'b1 : (b < int'(en[1:0]));
  endfunction

  function automatic exp_t idle_e(string tag);
    exp_t e;
    e.cs = 4'hF; e.oe = 1; e.rd = 1; e.we = 1; e.dn = 0; e.er = 0; e.bz = 0;
    e.rdy = 0; e.chk_rd = 0; e.rd_exp = '0; e.chk_wd = 0; e.wd_exp = '0;
    e.tag = tag;
    return e;
  endfunction

  // Per-cycle comparison against the model queue
  always @(negedge clk) begin
    exp_t e;
    if (!rst) begin
      if (q.size() > 0) e = q.pop_front();
      else e = idle_e("R9 idle");
      rdy = e.rdy;
      chk({mem_cs_n, mem_oe_n, mem_rd_n, mem_we_n} == {e.cs, e.oe, e.rd, e.we},
          e.tag, "strobes cs/oe/rd/we",
          {25'd0, mem_cs_n, mem_oe_n, mem_rd_n, mem_we_n},
          {25'd0, e.cs, e.oe, e.rd, e.we});
      chk({done, err, busy} == {e.dn, e.er, e.bz}, e.tag, "done/err/busy",
          {29'd0, done, err, busy}, {29'd0, e.dn, e.er, e.bz});
      if (e.chk_rd)
        chk(rdata == e.rd_exp, {e.tag, " R10"}, "rdata", 32'(rdata), 32'(e.rd_exp));
      if (e.chk_wd)
        chk(mem_wdata == e.wd_exp, {e.tag, " R4"}, "wdata", 32'(mem_wdata), 32'(e.wd_exp));
      if (e.bz && !e.oe)
        chk(mem_addr == addr, {e.tag, " R10"}, "addr", 32'(mem_addr), 32'(addr));
    end
  end

  task automatic issue(int b, bit w, logic [17:0] off, int extra, string tag);
    logic [15:0] f;
    exp_t e;
    int turn, su, hd, acc, tot;
    do begin
      @(negedge clk);
      #1;
    end while (q.size() != 0);
    f = fld(b);
    start = 1'b1;
    wr    = w;
    addr  = {2'(b), off};
    wdata = off[15:0] ^ 16'h3C3C;
    if (!usable(b)) begin
      e = idle_e(tag);
      e.dn = 1; e.er = 1;
      q.push_back(e);
    end else begin
      turn = wrap4(f[3:2]);
      su   = wrap4(f[5:4]);
      hd   = int'(f[7:6]);
      acc  = w ? int'(f[15:12]) : int'(f[11:8]);
      if (acc == 0) acc = 1;
      tot  = acc + (f[0] ? extra : 0);
      if (w && last_rd_m) begin
        for (int k = 0; k < turn; k++) begin
          e = idle_e(tag); e.bz = 1; e.rdy = ~f[1]; q.push_back(e);
        end
      end
      for (int k = 0; k < su; k++) begin
        e = idle_e(tag); e.bz = 1; e.cs = ~(4'b1 << b); e.oe = 0; e.rdy = ~f[1];
        q.push_back(e);
      end
      for (int k = 0; k < tot; k++) begin
        e = idle_e(tag); e.bz = 1; e.cs = ~(4'b1 << b); e.oe = 0;
        e.rd = w; e.we = !w;
        e.rdy = (f[0] && k >= tot - 1) ? f[1] : ~f[1];
        e.chk_wd = w; e.wd_exp = wdata;
        q.push_back(e);
      end
      for (int k = 0; k < hd; k++) begin
        e = idle_e(tag); e.bz = 1; e.cs = ~(4'b1 << b); e.oe = 0; e.rdy = ~f[1];
        q.push_back(e);
      end
      e = idle_e(tag); e.dn = 1;
      e.chk_rd = !w; e.rd_exp = addr[15:0] ^ 16'h5AC3;
      q.push_back(e);
      last_rd_m = !w;
    end
    @(negedge clk);
    #1;
    start = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    total++;
    bad++;
    $display("FAIL watchdog expired R9 act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 0; wr = 0; addr = '0; wdata = '0; rdy = 0;
    en  = 3'b100;
    // b0: setup 0->4, rd 3, wr 2, hold 0, turn 2, no ready
    // b1: setup 1, rd 0->1, wr 5, hold 3, turn 0->4, ready high
    // b2: setup 2, rd 2, wr 1, hold 1, turn 1, ready low
    // b3: setup 3, rd 4, wr 15, hold 2, turn 3, ready off
    lo = {16'h50D3, 16'h2308};
    hi = {16'hF4BE, 16'h1265};
    repeat (3) @(negedge clk);
    chk({mem_cs_n, mem_oe_n, mem_rd_n, mem_we_n, done, err, busy} == 10'b1111111000,
        "R9", "reset state", {22'd0, mem_cs_n, mem_oe_n, mem_rd_n, mem_we_n, done, err, busy},
        32'h3F8);
    @(posedge clk);
    #1;
    rst = 1'b0;

    issue(0, 0, 18'h00123, 0, "R3 R4 R8 read b0 setup wrap");
    issue(0, 0, 18'h00456, 0, "R6 read after read");
    issue(0, 1, 18'h00789, 0, "R6 write after read turn 2");
    issue(0, 1, 18'h00ABC, 0, "R6 write after write");
    issue(1, 0, 18'h01111, 3, "R7 ready high stretch");
    issue(1, 0, 18'h02222, 0, "R7 R4 ready at once, acc code 0");
    issue(1, 1, 18'h03333, 0, "R6 R5 turn wrap 4, hold 3");
    issue(2, 0, 18'h04444, 2, "R7 ready low polarity");
    issue(2, 1, 18'h05555, 1, "R6 R2 turn 1 bank2");
    issue(3, 0, 18'h06666, 4, "R7 ready disabled ignored");
    issue(3, 1, 18'h07777, 0, "R4 R5 write 15, turn 3");
    issue(3, 0, 18'h08888, 0, "R2 R8 read b3");
    en = 3'b010;
    issue(2, 0, 18'h09999, 0, "R1 code 010 bank2 off");
    issue(3, 1, 18'h0AAAA, 0, "R1 code 010 bank3 off");
    issue(1, 1, 18'h0BBBB, 0, "R1 R6 code 010 bank1 on");
    en = 3'b000;
    issue(0, 0, 18'h0CCCC, 0, "R1 code 000 bank0 off");
    en = 3'b001;
    issue(0, 0, 18'h0DDDD, 0, "R1 code 001 bank0 on");
    issue(1, 0, 18'h0EEEE, 0, "R1 code 001 bank1 off");
    en = 3'b011;
    issue(2, 1, 18'h0F0F0, 0, "R1 R6 code 011 bank2 on");
    issue(3, 0, 18'h10101, 0, "R1 code 011 bank3 off");
    en = 3'b111;
    issue(3, 0, 18'h12345, 0, "R1 code 111 bank3 on");
    do begin
      @(negedge clk);
      #1;
    end while (q.size() != 0);
    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule